// File: doc/BRIEF.md
# Late-Write Pipelined SRAM Core

A synchronous single-data-rate static memory with a registered read path and a late write path. Every input is sampled on the rising clock edge. A read returns its word one full cycle after the command edge, through an output register. A write takes its address, command and byte mask at one edge and its data at the next edge. Memory holds 2^ADDR_W words, each made of LANES lanes of LANE_W bits. Each lane has its own active-low enable.

The pending late write sits in a holding register until its data arrives. A read that follows it at once takes the incoming lanes through a bypass, so read and write stay coherent. Three chip enables gate the block. Two of them have a polarity set by static strap inputs, and only those two gate the echo clock pair. When the advance input is high on a selected cycle, the next address is formed inside the block. The 2-bit low field of the previous address steps by one and wraps, and the previous operation type is kept. The bidirectional data bus is presented as separate data-in, data-out and output-enable signals.

Top module: `lw_sram_core`

## Requirements
- R1: While `rst_n` is low, and right after it, `q_oe_o` is 0. The echo pair is gated during reset: in the high clock phase `cq_o` is 0 and `cq_n_o` is 1.
- R2: A read is accepted when the block is selected, `adv_i` is 0 and `we_n_i` is 1 at edge k. The word at `addr_i` appears on `q_o`, with `q_oe_o` = 1, in the cycle that follows edge k+1.
- R3: `q_oe_o` is 1 only in the cycle after an accepted read has passed its output register. In every other cycle `q_oe_o` is 0 and `q_o` keeps its last value.
- R4: A write is accepted when the block is selected, `adv_i` is 0 and `we_n_i` is 0 at edge k. Its data is taken from `d_i` at edge k+1. A write never raises `q_oe_o`.
- R5: Lane l is bits [l*LANE_W+LANE_W-1 : l*LANE_W]. A lane is written only when `bw_n_i[l]` is 0 at the command edge. The other lanes of the word are left unchanged.
- R6: A write with every `bw_n_i` bit at 1 is an abort. Memory is left unchanged.
- R7: `ce1_n_i` is active low. `ce2_i` is active when it equals `ce2_pol_i`, and `ce3_i` is active when it equals `ce3_pol_i` (a strap value of 1 means active high). The block is selected only when all three enables are active.
- R8: At an edge where any enable is inactive, no read and no write is accepted. Two cycles later `q_oe_o` is 0.
- R9: If `ce2_i` and `ce3_i` were both active at the last edge, `cq_o` follows the clock and `cq_n_o` is its inverse. Otherwise `cq_o` is 0 and `cq_n_o` is 1. `ce1_n_i` has no effect on the echo pair.
- R10: A read of an address whose late write gets its data at the same edge returns the new lanes of that write. The lanes it did not enable keep their previous contents.
- R11: When `adv_i` is 1 on a selected edge, the block repeats the last loaded operation type at the previous address with its low 2 bits incremented, wrapping from 3 to 0. For a burst write the lane mask is taken from `bw_n_i` at that edge. Before the first load, a high `adv_i` does nothing.
- R12: If the block is deselected at the edge right after an accepted read, that read's data is still delivered with `q_oe_o` = 1. The output enable drops one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| addr_i | input | ADDR_W | Word address, loaded when `adv_i` is 0 |
| adv_i | input | 1 | 1 = advance the internal address, 0 = load `addr_i` |
| we_n_i | input | 1 | 0 = write, 1 = read, on a load |
| bw_n_i | input | LANES | Active-low lane write enables |
| ce1_n_i | input | 1 | Active-low chip enable |
| ce2_i | input | 1 | Chip enable with strap polarity |
| ce3_i | input | 1 | Chip enable with strap polarity |
| ce2_pol_i | input | 1 | Static strap: active level of `ce2_i` |
| ce3_pol_i | input | 1 | Static strap: active level of `ce3_i` |
| d_i | input | LANES*LANE_W | Write data, one edge after its command |
| q_o | output | LANES*LANE_W | Registered read data |
| q_oe_o | output | 1 | Drive enable for the data bus |
| cq_o | output | 1 | Echo clock, true phase |
| cq_n_o | output | 1 | Echo clock, inverted phase |

## Verification
The assertions assume that the strap pins stay constant and that `adv_i`, `we_n_i` and the enables are never unknown at a sampling edge. They also assume that write data is presented exactly one edge after its command. The stimulus changes every input only on the falling edge. It changes the straps only while the block is idle and deselected. Every read targets an address that has already been written, so every expected value is defined. The echo pair is combinational from the clock, so the bench samples it one nanosecond into the high phase and not at an edge.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    // Operation carried through a command and repeated by the burst counter
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

endpackage

// File: rtl/lw_cmd_decode.sv
module lw_cmd_decode
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int BURST_W = 2
) (
    input  logic              ce1_n_i,
    input  logic              ce2_i,
    input  logic              ce3_i,
    input  logic              ce2_pol_i,
    input  logic              ce3_pol_i,
    input  logic              adv_i,
    input  logic              we_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] last_addr_i,
    input  op_e               last_op_i,
    output logic              echo_en_o,
    output logic              load_o,
    output logic              go_o,
    output op_e               cmd_op_o,
    output logic [ADDR_W-1:0] cmd_addr_o
);

    logic               sel;
    logic [BURST_W-1:0] step;
    logic [ADDR_W-1:0]  burst_addr;

    assign echo_en_o = (ce2_i == ce2_pol_i) && (ce3_i == ce3_pol_i);
    assign sel       = !ce1_n_i && echo_en_o;
    assign step      = last_addr_i[BURST_W-1:0] + BURST_W'(1);

    // Only the low burst field advances; upper bits stay fixed
    generate
        if (ADDR_W > BURST_W) begin : g_wide
            assign burst_addr = {last_addr_i[ADDR_W-1:BURST_W], step};
        end else begin : g_narrow
            assign burst_addr = step;
        end
    endgenerate

    always_comb begin
        load_o     = sel && !adv_i;
        go_o       = load_o || (sel && adv_i && (last_op_i != OP_NONE));
        cmd_op_o   = adv_i ? last_op_i : (we_n_i ? OP_READ : OP_WRITE);
        cmd_addr_o = adv_i ? burst_addr : addr_i;
    end

endmodule

// File: rtl/lw_lane_merge.sv
module lw_lane_merge #(
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic [LANES*LANE_W-1:0] base_i,
    input  logic [LANES*LANE_W-1:0] over_i,
    input  logic [LANES-1:0]        mask_i,
    output logic [LANES*LANE_W-1:0] word_o
);

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign word_o[l*LANE_W +: LANE_W] = mask_i[l] ? over_i[l*LANE_W +: LANE_W]
                                                          : base_i[l*LANE_W +: LANE_W];
        end
    endgenerate

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    ren_i,
    input  logic [ADDR_W-1:0]       raddr_i,
    output logic [LANES*LANE_W-1:0] rdata_o,
    input  logic [LANES-1:0]        wmask_i,
    input  logic [ADDR_W-1:0]       waddr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i
);

    localparam int DEPTH = 1 << ADDR_W;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [LANE_W-1:0] mem [DEPTH];
            logic [LANE_W-1:0] rd_q;

            always_ff @(posedge clk) begin
                if (wmask_i[l]) begin
                    mem[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
                end
                if (ren_i) begin
                    rd_q <= mem[raddr_i];
                end
            end

            assign rdata_o[l*LANE_W +: LANE_W] = rd_q;
        end
    endgenerate

endmodule

// File: rtl/lw_sram_core.sv
module lw_sram_core
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int LANES   = 2,
    parameter int LANE_W  = 9,
    parameter int BURST_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    adv_i,
    input  logic                    we_n_i,
    input  logic [LANES-1:0]        bw_n_i,
    input  logic                    ce1_n_i,
    input  logic                    ce2_i,
    input  logic                    ce3_i,
    input  logic                    ce2_pol_i,
    input  logic                    ce3_pol_i,
    input  logic [LANES*LANE_W-1:0] d_i,
    output logic [LANES*LANE_W-1:0] q_o,
    output logic                    q_oe_o,
    output logic                    cq_o,
    output logic                    cq_n_o
);

    localparam int DW = LANES * LANE_W;

    typedef struct packed {
        logic [ADDR_W-1:0] last_addr;
        op_e               last_op;
        logic              rd_vld;
        logic [LANES-1:0]  byp_mask;
        logic [DW-1:0]     byp_data;
        logic [ADDR_W-1:0] pend_addr;
        logic [LANES-1:0]  pend_mask;
        logic              pend_vld;
        logic [DW-1:0]     q;
        logic              oe;
        logic              cq_en;
    } state_t;

    state_t st_q, st_d;

    logic              echo_en, load, go;
    op_e               cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic              do_rd, do_wr, hit;
    logic [LANES-1:0]  cmd_mask, wmask;
    logic [DW-1:0]     arr_rdata, merged;

    lw_cmd_decode #(
        .ADDR_W  (ADDR_W),
        .BURST_W (BURST_W)
    ) u_dec (
        .ce1_n_i     (ce1_n_i),
        .ce2_i       (ce2_i),
        .ce3_i       (ce3_i),
        .ce2_pol_i   (ce2_pol_i),
        .ce3_pol_i   (ce3_pol_i),
        .adv_i       (adv_i),
        .we_n_i      (we_n_i),
        .addr_i      (addr_i),
        .last_addr_i (st_q.last_addr),
        .last_op_i   (st_q.last_op),
        .echo_en_o   (echo_en),
        .load_o      (load),
        .go_o        (go),
        .cmd_op_o    (cmd_op),
        .cmd_addr_o  (cmd_addr)
    );

    lw_sram_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_arr (
        .clk     (clk),
        .ren_i   (do_rd),
        .raddr_i (cmd_addr),
        .rdata_o (arr_rdata),
        .wmask_i (wmask),
        .waddr_i (st_q.pend_addr),
        .wdata_i (d_i)
    );

    lw_lane_merge #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_merge (
        .base_i (arr_rdata),
        .over_i (st_q.byp_data),
        .mask_i (st_q.byp_mask),
        .word_o (merged)
    );

    always_comb begin
        do_rd    = go && (cmd_op == OP_READ);
        do_wr    = go && (cmd_op == OP_WRITE);
        cmd_mask = ~bw_n_i;
        wmask    = st_q.pend_vld ? st_q.pend_mask : '0;
        hit      = do_rd && st_q.pend_vld && (st_q.pend_addr == cmd_addr);

        st_d           = st_q;
        st_d.last_addr = go ? cmd_addr : st_q.last_addr;
        if (load) begin
            st_d.last_op = cmd_op;
        end
        // Stage 1: array read in flight, with lanes of a same-edge write captured
        st_d.rd_vld   = do_rd;
        st_d.byp_mask = hit ? st_q.pend_mask : '0;
        st_d.byp_data = d_i;
        // Late write waits here for its data at the next edge
        st_d.pend_addr = cmd_addr;
        st_d.pend_mask = cmd_mask;
        st_d.pend_vld  = do_wr && (|cmd_mask);
        // Stage 2: output register and bus enable
        st_d.q     = st_q.rd_vld ? merged : st_q.q;
        st_d.oe    = st_q.rd_vld;
        st_d.cq_en = echo_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o    = st_q.q;
    assign q_oe_o = st_q.oe;
    assign cq_o   = clk & st_q.cq_en;
    assign cq_n_o = ~cq_o;

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          adv_i,
    input logic          we_n_i,
    input logic          ce1_n_i,
    input logic          ce2_i,
    input logic          ce3_i,
    input logic          ce2_pol_i,
    input logic          ce3_pol_i,
    input logic [DW-1:0] q_o,
    input logic          q_oe_o
);

    logic selected;
    assign selected = !ce1_n_i && (ce2_i == ce2_pol_i) && (ce3_i == ce3_pol_i);

    AST_READ_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (selected && !adv_i && we_n_i) |-> ##2 q_oe_o);                     // R2

    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (selected && !adv_i && !we_n_i) |-> ##2 !q_oe_o);                   // R4

    AST_DRIVE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        q_oe_o |-> $past(selected, 2));                                     // R8

    AST_CE1_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ce1_n_i |-> ##2 !q_oe_o);                                           // R7

    AST_Q_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !q_oe_o |-> $stable(q_o));                                          // R3

endmodule

bind lw_sram_core lw_sram_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_lw_sram_core.sv
module sim_lw_sram_core;

    localparam int AW = 6;
    localparam int LN = 2;
    localparam int LW = 9;
    localparam int DW = LN * LW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          adv, we_n;
    logic [LN-1:0] bw_n;
    logic          ce1_n, ce2, ce3, pol2, pol3;
    logic [DW-1:0] d;
    logic [DW-1:0] q;
    logic          oe, cq, cq_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    lw_sram_core #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .adv_i(adv), .we_n_i(we_n),
        .bw_n_i(bw_n), .ce1_n_i(ce1_n), .ce2_i(ce2), .ce3_i(ce3),
        .ce2_pol_i(pol2), .ce3_pol_i(pol3), .d_i(d), .q_o(q), .q_oe_o(oe),
        .cq_o(cq), .cq_n_o(cq_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        ce1_n = 1'b1; adv = 1'b0; we_n = 1'b1; bw_n = '1; addr = '0;
    endtask

    task automatic set_cmd(input logic [AW-1:0] a, input logic wn, input logic [LN-1:0] bwn);
        ce1_n = 1'b0; adv = 1'b0; we_n = wn; bw_n = bwn; addr = a;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [LN-1:0] bwn, input logic [DW-1:0] data);
        set_cmd(a, 1'b0, bwn);
        tick();
        idle();
        d = data;
        tick();
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        set_cmd(a, 1'b1, '1);
        tick();
        idle();
        tick();
        chk(oe === 1'b1, req, oe, 1);
        chk(q === exp, req, q, exp);
        tick();
        chk(oe === 1'b0, req, oe, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle();
        ce2 = 1'b1; ce3 = 1'b1; pol2 = 1'b1; pol3 = 1'b1; d = '0;
        repeat (3) tick();
        chk(oe === 1'b0, "R1 oe in reset", oe, 0);
        @(posedge clk); #1;
        chk(cq === 1'b0 && cq_n === 1'b1, "R1 echo gated in reset", {cq, cq_n}, 2'b01);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk(oe === 1'b0, "R1 oe after reset", oe, 0);
    endtask

    task automatic t_basic();
        do_write(6'd5, 2'b00, 18'h2A5A5);
        do_write(6'd12, 2'b00, 18'h1C3F0);
        do_read(6'd5, 18'h2A5A5, "R2 read addr 5");
        do_read(6'd12, 18'h1C3F0, "R4 read addr 12");
        // Write cycle never drives the bus
        set_cmd(6'd13, 1'b0, 2'b00);
        tick();
        idle(); d = 18'h00111;
        tick();
        chk(oe === 1'b0, "R4 no oe on write", oe, 0);
        tick();
        chk(oe === 1'b0, "R4 no oe on write later", oe, 0);
    endtask

    task automatic t_lanes();
        do_write(6'd30, 2'b00, 18'h3FE01);
        do_write(6'd30, 2'b10, 18'h00155);   // lane 0 only
        do_read(6'd30, {9'h1FF, 9'h155}, "R5 lane0 only");
        do_write(6'd30, 2'b01, 18'h0AA00);   // lane 1 only
        do_read(6'd30, {9'h055, 9'h155}, "R5 lane1 only");
    endtask

    task automatic t_abort();
        do_write(6'd30, 2'b11, 18'h12345);
        do_read(6'd30, {9'h055, 9'h155}, "R6 abort leaves word");
    endtask

    task automatic t_coherent();
        do_write(6'd20, 2'b00, 18'h0F0F0);
        set_cmd(6'd20, 1'b0, 2'b01);         // lane 1 write
        tick();
        set_cmd(6'd20, 1'b1, '1);            // read in the data edge
        d = 18'h2B2B2;
        tick();
        idle();
        tick();
        chk(oe === 1'b1, "R10 oe", oe, 1);
        chk(q === {9'h159, 9'h0F0}, "R10 bypass merge", q, {9'h159, 9'h0F0});
        tick();
        do_read(6'd20, {9'h159, 9'h0F0}, "R10 committed");
    endtask

    task automatic t_polarity();
        idle();
        pol2 = 1'b0; pol3 = 1'b0; ce2 = 1'b0; ce3 = 1'b0;
        tick();
        do_write(6'd9, 2'b00, 18'h01234);
        do_read(6'd9, 18'h01234, "R7 low polarity");
        ce2 = 1'b1;                          // now inactive
        set_cmd(6'd9, 1'b0, 2'b00);
        tick();
        idle(); d = 18'h3FFFF;
        tick();
        ce2 = 1'b0;
        do_read(6'd9, 18'h01234, "R8 write ignored");
        ce3 = 1'b1;
        set_cmd(6'd9, 1'b1, '1);
        tick();
        idle();
        tick();
        chk(oe === 1'b0, "R8 read ignored", oe, 0);
        tick();
        idle();
        pol2 = 1'b1; pol3 = 1'b1; ce2 = 1'b1; ce3 = 1'b1;
        tick();
    endtask

    task automatic t_echo();
        idle();
        ce2 = 1'b0;
        tick();
        @(posedge clk); #1;
        chk(cq === 1'b0 && cq_n === 1'b1, "R9 gated by ce2", {cq, cq_n}, 2'b01);
        @(negedge clk);
        ce2 = 1'b1; ce3 = 1'b0;
        @(posedge clk); #1;
        chk(cq === 1'b0 && cq_n === 1'b1, "R9 gated by ce3", {cq, cq_n}, 2'b01);
        @(negedge clk);
        ce3 = 1'b1;                          // ce1 still inactive
        @(posedge clk); #1;
        chk(cq === 1'b1 && cq_n === 1'b0, "R9 running with ce1 off", {cq, cq_n}, 2'b10);
        @(negedge clk);
        chk(cq === 1'b0 && cq_n === 1'b1, "R9 low phase", {cq, cq_n}, 2'b01);
    endtask

    task automatic t_burst();
        do_write(6'd5, 2'b00, 18'h00ABC);
        set_cmd(6'd6, 1'b0, 2'b00);          // load write 6
        tick();
        adv = 1'b1; we_n = 1'b1; d = 18'h11111;   // burst -> 7
        tick();
        adv = 1'b1; d = 18'h22222;           // burst -> 4 (wrap)
        tick();
        idle(); d = 18'h33333;
        tick();
        do_read(6'd6, 18'h11111, "R11 burst first");
        do_read(6'd7, 18'h22222, "R11 burst step");
        do_read(6'd4, 18'h33333, "R11 burst wrap");
        set_cmd(6'd4, 1'b1, '1);             // load read 4
        tick();
        adv = 1'b1; we_n = 1'b0;             // burst keeps read -> 5
        tick();
        idle();
        chk(oe === 1'b1 && q === 18'h33333, "R11 burst read 4", q, 18'h33333);
        tick();
        chk(oe === 1'b1 && q === 18'h00ABC, "R11 burst read 5", q, 18'h00ABC);
        tick();
        chk(oe === 1'b0, "R11 burst end", oe, 0);
    endtask

    task automatic t_desel();
        set_cmd(6'd12, 1'b1, '1);
        tick();
        idle();                              // deselect right after the read
        tick();
        chk(oe === 1'b1, "R12 oe after deselect", oe, 1);
        chk(q === 18'h1C3F0, "R12 data after deselect", q, 18'h1C3F0);
        tick();
        chk(oe === 1'b0, "R12 oe drops", oe, 0);
        tick();
        chk(q === 18'h1C3F0, "R3 q holds", q, 18'h1C3F0);
        chk(oe === 1'b0, "R3 oe stays low", oe, 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_lanes();
        t_abort();
        t_coherent();
        t_polarity();
        t_echo();
        t_burst();
        t_desel();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule